// File: doc/BRIEF.md
# Flash Lock-Bit Protection Controller

This block is the command front end and write-protection arbiter for a flash array divided into blocks. Each block has one lock bit, and the whole array has one master lock bit. Bus write cycles present a command byte and a block index. Sideband inputs report whether the supply is valid and whether the program voltage is valid. A two-level reset pin is modelled as two flags: `rp_low` (pin pulled low) and `rp_ovr` (pin raised to the elevated override level).

From these inputs the controller decides whether an operation may run. The operations are block erase, byte program, setting one block lock, setting the master lock, and clearing every block lock at once. A permitted operation runs a timed busy phase of `BUSY_CYC` cycles. A refused operation records its cause in a sticky status byte.

The lock storage lives inside the block. The array data and the erase or program algorithms are not modelled: only the busy time stands in for them.

Top module: `flash_lock_ctrl`

## Requirements
- R1: After reset the status byte reads 0x80. `ready` is 1, all lock bits and the master lock are 0, the indeterminate flag is 0, and `rd_status_mode` is 0 (array read).
- R2: An accepted operation holds `ready` and status bit 7 at 0 for exactly `BUSY_CYC` clock cycles, then sets both to 1. Bus writes made during the busy phase are ignored.
- R3: Writing 0x60 then 0x01 with block index b sets the lock bit of block b only, when the master lock is 0 and the program voltage is valid.
- R4: Erase is 0x20 then 0xD0, and program is 0x40 then any data byte. Either one on a block whose lock bit is 1 runs only when `rp_ovr`=1. Otherwise erase sets status bits 5 and 1, and program sets status bits 4 and 1. An unlocked block may be erased or programmed without override.
- R5: Setting the master lock (0x60 then 0xF1) runs only when `rp_ovr`=1. Without override it sets status bits 4 and 1, and the master lock stays 0.
- R6: When the master lock is 1, setting a block lock needs `rp_ovr`=1. Without override it sets status bits 4 and 1, and the lock bits stay unchanged.
- R7: Clearing all block locks is 0x60 then 0xD0, and it clears every lock bit on the same clock edge. When the master lock is 1 and `rp_ovr`=0, the clear instead sets status bits 5 and 1 and leaves the lock bits unchanged.
- R8: If `vpp_ok`=0 when a clear is confirmed, status bits 5 and 3 are set and the lock bits stay unchanged.
- R9: After 0x60 or 0x20, an unrecognized second byte sets status bits 5 and 4 and starts nothing.
- R10: Error bits 5, 4, 3 and 1 stay set across other commands, including 0x70. Only the clear-status command 0x50 returns them to 0.
- R11: A clear operation is aborted when `vcc_ok` or `vpp_ok` falls, or `rp_low` rises, while it is busy. The abort sets the indeterminate flag and leaves the lock bits unchanged. An abort seen in the final busy cycle wins over completion. A later clear that completes resets the flag.
- R12: No operation clears the master lock once it is set.
- R13: `rd_status_mode` is 1 after any setup or confirm write, and after 0x70. It stays 1 until 0xFF is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_cmd | input | 8 | Command or data byte |
| wr_blk | input | BLK_W | Block index carried with the write |
| vcc_ok | input | 1 | Supply in valid range |
| vpp_ok | input | 1 | Program voltage above lockout |
| rp_low | input | 1 | Reset pin driven low |
| rp_ovr | input | 1 | Reset pin at elevated override level |
| ready | output | 1 | Ready (1) / busy (0) pin |
| status | output | 8 | Status byte |
| rd_status_mode | output | 1 | Reads return status (1) or array (0) |
| lock_bits | output | NUM_BLOCKS | Per-block lock bits |
| master_lock | output | 1 | Master lock bit |
| lock_indet | output | 1 | Lock bits indeterminate after an aborted clear |

## Verification
Two events can fall on the same clock edge: the last tick of the busy counter, which would commit a clear-all, and an abort caused by a supply drop. The bench confirms a clear with override. It then waits exactly `BUSY_CYC`-1 edges and lowers `vcc_ok` so that the drop is sampled on the completion edge. The expected result is that the abort wins: the lock bits are unchanged, the indeterminate flag is 1, and status reads 0x80. A repeated clear must then empty the locks and reset the flag.

// File: rtl/flc_pkg.sv
package flc_pkg;
  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_READ_STATUS = 8'h70;
  localparam logic [7:0] CMD_CLR_STATUS  = 8'h50;
  localparam logic [7:0] CMD_LOCK_SETUP  = 8'h60;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
  localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
  localparam logic [7:0] CMD_SET_BLOCK   = 8'h01;
  localparam logic [7:0] CMD_SET_MASTER  = 8'hF1;

  localparam int ERR_W = 7;
  localparam logic [ERR_W-1:0] E_ERASE = 7'h20;
  localparam logic [ERR_W-1:0] E_PROG  = 7'h10;
  localparam logic [ERR_W-1:0] E_VPP   = 7'h08;
  localparam logic [ERR_W-1:0] E_LOCK  = 7'h02;

  typedef enum logic [2:0] {
    ST_ARRAY, ST_STATUS, ST_LOCK_SU, ST_ERASE_SU, ST_PROG_SU, ST_BUSY
  } flc_state_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_ERASE, OP_PROG, OP_SETB, OP_SETM, OP_CLRALL
  } flc_op_e;
endpackage

// File: rtl/flc_decide.sv
module flc_decide
  import flc_pkg::*;
(
  input  flc_state_e            state,
  input  logic [7:0]            cmd,
  input  logic                  blk_locked,
  input  logic                  master,
  input  logic                  vpp_ok,
  input  logic                  ovr,
  output flc_op_e               op,
  output logic [ERR_W-1:0]      err
);
  always_comb begin
    op  = OP_NONE;
    err = '0;
    case (state)
      ST_LOCK_SU: begin
        case (cmd)
          CMD_CONFIRM: begin
            if (!vpp_ok)              err = E_VPP | E_ERASE;
            else if (master && !ovr)  err = E_LOCK | E_ERASE;
            else                      op  = OP_CLRALL;
          end
          CMD_SET_BLOCK: begin
            if (!vpp_ok)              err = E_VPP | E_PROG;
            else if (master && !ovr)  err = E_LOCK | E_PROG;
            else                      op  = OP_SETB;
          end
          CMD_SET_MASTER: begin
            if (!vpp_ok)              err = E_VPP | E_PROG;
            else if (!ovr)            err = E_LOCK | E_PROG;
            else                      op  = OP_SETM;
          end
          default:                    err = E_PROG | E_ERASE;
        endcase
      end
      ST_ERASE_SU: begin
        if (cmd != CMD_CONFIRM)           err = E_PROG | E_ERASE;
        else if (!vpp_ok)                 err = E_VPP | E_ERASE;
        else if (blk_locked && !ovr)      err = E_LOCK | E_ERASE;
        else                              op  = OP_ERASE;
      end
      ST_PROG_SU: begin
        if (!vpp_ok)                      err = E_VPP | E_PROG;
        else if (blk_locked && !ovr)      err = E_LOCK | E_PROG;
        else                              op  = OP_PROG;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/flc_busy_timer.sv
module flc_busy_timer #(
  parameter int BUSY_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic abort,
  output logic done
);
  localparam int CNT_W = (BUSY_CYC > 1) ? $clog2(BUSY_CYC + 1) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;

  assign done = active_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      cnt_q    <= LOAD;
    end else if (active_q) begin
      if (abort || done) active_q <= 1'b0;
      else               cnt_q    <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/flc_lock_store.sv
module flc_lock_store #(
  parameter int NUM_BLOCKS = 16,
  parameter int BLK_W      = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  set_en,
  input  logic [BLK_W-1:0]      set_blk,
  input  logic                  clr_all,
  input  logic                  set_master,
  input  logic                  mark_indet,
  output logic [NUM_BLOCKS-1:0] locks,
  output logic                  master,
  output logic                  indet
);
  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_lock
    always_ff @(posedge clk) begin
      if (rst)                                     locks[g] <= 1'b0;
      else if (clr_all)                            locks[g] <= 1'b0;
      else if (set_en && set_blk == BLK_W'(g))     locks[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      master <= 1'b0;
      indet  <= 1'b0;
    end else begin
      if (set_master) master <= 1'b1;
      if (mark_indet)   indet <= 1'b1;
      else if (clr_all) indet <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl
  import flc_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  parameter int BUSY_CYC   = 8,
  localparam int BLK_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [7:0]            wr_cmd,
  input  logic [BLK_W-1:0]      wr_blk,
  input  logic                  vcc_ok,
  input  logic                  vpp_ok,
  input  logic                  rp_low,
  input  logic                  rp_ovr,
  output logic                  ready,
  output logic [7:0]            status,
  output logic                  rd_status_mode,
  output logic [NUM_BLOCKS-1:0] lock_bits,
  output logic                  master_lock,
  output logic                  lock_indet
);
  flc_state_e        state_q, state_d;
  flc_op_e           op_q, dec_op;
  logic [BLK_W-1:0]  blk_q;
  logic [ERR_W-1:0]  err_q, err_d, dec_err;
  logic              ready_q, ready_d, mode_q;
  logic              tmr_start, tmr_done, busy_abort, finish;

  flc_decide u_decide (
    .state(state_q), .cmd(wr_cmd), .blk_locked(lock_bits[wr_blk]),
    .master(master_lock), .vpp_ok(vpp_ok), .ovr(rp_ovr),
    .op(dec_op), .err(dec_err)
  );

  assign busy_abort = (state_q == ST_BUSY) && (!vcc_ok || !vpp_ok || rp_low);
  assign finish     = (state_q == ST_BUSY) && tmr_done && !busy_abort;
  assign tmr_start  = (state_d == ST_BUSY) && (state_q != ST_BUSY);

  flc_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_timer (
    .clk(clk), .rst(rst), .start(tmr_start), .abort(busy_abort), .done(tmr_done)
  );

  flc_lock_store #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_store (
    .clk(clk), .rst(rst),
    .set_en(finish && op_q == OP_SETB), .set_blk(blk_q),
    .clr_all(finish && op_q == OP_CLRALL),
    .set_master(finish && op_q == OP_SETM),
    .mark_indet(busy_abort && op_q == OP_CLRALL),
    .locks(lock_bits), .master(master_lock), .indet(lock_indet)
  );

  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    ready_d = ready_q;
    case (state_q)
      ST_ARRAY, ST_STATUS: begin
        if (wr_en) begin
          case (wr_cmd)
            CMD_READ_ARRAY:  state_d = ST_ARRAY;
            CMD_READ_STATUS: state_d = ST_STATUS;
            CMD_CLR_STATUS:  err_d   = '0;
            CMD_LOCK_SETUP:  state_d = ST_LOCK_SU;
            CMD_ERASE_SETUP: state_d = ST_ERASE_SU;
            CMD_PROG_SETUP:  state_d = ST_PROG_SU;
            default: ;
          endcase
        end
      end
      ST_LOCK_SU, ST_ERASE_SU, ST_PROG_SU: begin
        if (wr_en) begin
          err_d = err_q | dec_err;
          if (dec_op != OP_NONE) begin
            state_d = ST_BUSY;
            ready_d = 1'b0;
          end else begin
            state_d = ST_STATUS;
          end
        end
      end
      ST_BUSY: begin
        if (busy_abort || tmr_done) begin
          state_d = ST_STATUS;
          ready_d = 1'b1;
        end
      end
      default: state_d = ST_ARRAY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_ARRAY;
      err_q   <= '0;
      ready_q <= 1'b1;
      mode_q  <= 1'b0;
      op_q    <= OP_NONE;
      blk_q   <= '0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      ready_q <= ready_d;
      mode_q  <= (state_d != ST_ARRAY);
      if (tmr_start) begin
        op_q  <= dec_op;
        blk_q <= wr_blk;
      end
    end
  end

  assign ready          = ready_q;
  assign status         = {ready_q, err_q};
  assign rd_status_mode = mode_q;
endmodule

// File: rtl/flash_lock_ctrl_chk.sv
module flash_lock_ctrl_chk #(
  parameter int NUM_BLOCKS = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_en,
  input logic [7:0]            wr_cmd,
  input logic                  vcc_ok,
  input logic                  vpp_ok,
  input logic                  rp_low,
  input logic                  ready,
  input logic [7:0]            status,
  input logic [NUM_BLOCKS-1:0] lock_bits,
  input logic                  master_lock,
  input logic                  lock_indet
);
  a_r2_ready_pin_mirror: assert property (@(posedge clk) disable iff (rst)
    ready == status[7]);

  a_r12_master_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(master_lock) |-> master_lock);

  a_r10_err_cleared_only_by_cmd: assert property (@(posedge clk) disable iff (rst)
    (($past(status[5:1]) & ~status[5:1] & 5'b11101) != 5'b0)
      |-> $past(wr_en && wr_cmd == 8'h50));

  a_r3_one_lock_at_a_time: assert property (@(posedge clk) disable iff (rst)
    $countones(lock_bits & ~$past(lock_bits)) <= 1);

  a_r11_indet_needs_fault: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_indet) |-> $past(!vcc_ok || !vpp_ok || rp_low));
endmodule

bind flash_lock_ctrl flash_lock_ctrl_chk #(.NUM_BLOCKS(NUM_BLOCKS)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_cmd(wr_cmd),
  .vcc_ok(vcc_ok), .vpp_ok(vpp_ok), .rp_low(rp_low),
  .ready(ready), .status(status), .lock_bits(lock_bits),
  .master_lock(master_lock), .lock_indet(lock_indet)
);

// File: tb/flash_lock_ctrl_bench.sv
module flash_lock_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB   = 8;
  localparam int BW   = 3;
  localparam int BUSY = 5;

  logic clk = 0, rst = 1, wr_en = 0;
  logic [7:0] wr_cmd = 8'h00;
  logic [BW-1:0] wr_blk = '0;
  logic vcc_ok = 1, vpp_ok = 1, rp_low = 0, rp_ovr = 0;
  logic ready, rd_status_mode, master_lock, lock_indet;
  logic [7:0] status;
  logic [NB-1:0] lock_bits;

  flash_lock_ctrl #(.NUM_BLOCKS(NB), .BUSY_CYC(BUSY)) u_flash_lock_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_cmd(wr_cmd), .wr_blk(wr_blk),
    .vcc_ok(vcc_ok), .vpp_ok(vpp_ok), .rp_low(rp_low), .rp_ovr(rp_ovr),
    .ready(ready), .status(status), .rd_status_mode(rd_status_mode),
    .lock_bits(lock_bits), .master_lock(master_lock), .lock_indet(lock_indet)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    string         tag;
    logic [7:0]    st;
    logic [NB-1:0] lk;
    logic          m;
    logic          ind;
    logic          md;
  } exp_t;

  exp_t sbq[$];
  logic sample_req = 0;
  int   n_cmp = 0, n_bad = 0;
  bit   done_flag = 0;

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // monitor: pops the expected item and compares at the falling edge
  always @(negedge clk) begin
    if (sample_req && sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      n_cmp++;
      if (status !== e.st || ready !== e.st[7] || lock_bits !== e.lk ||
          master_lock !== e.m || lock_indet !== e.ind || rd_status_mode !== e.md) begin
        n_bad++;
        $display("FAIL %s: got st=%h rdy=%b lk=%b m=%b ind=%b md=%b exp st=%h lk=%b m=%b ind=%b md=%b",
                 e.tag, status, ready, lock_bits, master_lock, lock_indet, rd_status_mode,
                 e.st, e.lk, e.m, e.ind, e.md);
      end
    end
  end

  task automatic expect_state(string tag, logic [7:0] st, logic [NB-1:0] lk,
                              logic m, logic ind, logic md);
    exp_t e;
    e.tag = tag; e.st = st; e.lk = lk; e.m = m; e.ind = ind; e.md = md;
    sbq.push_back(e);
    sample_req = 1;
    @(posedge clk); #1;
    sample_req = 0;
  endtask

  task automatic direct_check(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d exp %0d", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] c, logic [BW-1:0] b);
    wr_cmd = c; wr_blk = b; wr_en = 1;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready) begin
      @(posedge clk); #1;
      n++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    report();
  end

  initial begin
    int n;
    repeat (4) @(posedge clk); #1;
    rst = 0;
    @(posedge clk); #1;
    expect_state("R1 reset", 8'h80, 8'h00, 0, 0, 0);

    // R3 set lock on block 3; R2 busy length and ignored writes
    wr(8'h60, 3'd3); wr(8'h01, 3'd3);
    wr(8'h60, 3'd0);                       // during busy: must be ignored
    n = 1; wait_ready(n); n = n + 1;
    direct_check("R2 busy cycles", n, BUSY);
    wr(8'h01, 3'd5);                       // would set lock 5 if 0x60 had been taken
    expect_state("R3 R2 set block lock, busy write ignored", 8'h80, 8'h08, 0, 0, 1);

    // R4 erase / program of locked block
    wr(8'h20, 3'd3); wr(8'hD0, 3'd3);
    expect_state("R4 erase locked", 8'hA2, 8'h08, 0, 0, 1);
    wr(8'h70, 3'd0);
    expect_state("R10 sticky across read status", 8'hA2, 8'h08, 0, 0, 1);
    wr(8'h50, 3'd0);
    expect_state("R10 clear status", 8'h80, 8'h08, 0, 0, 1);
    wr(8'h40, 3'd3); wr(8'h5A, 3'd3);
    expect_state("R4 program locked", 8'h92, 8'h08, 0, 0, 1);
    wr(8'h50, 3'd0);
    rp_ovr = 1;
    wr(8'h20, 3'd3); wr(8'hD0, 3'd3); wait_ready(n);
    expect_state("R4 erase locked with override", 8'h80, 8'h08, 0, 0, 1);
    rp_ovr = 0;
    wr(8'h40, 3'd2); wr(8'h11, 3'd2); wait_ready(n);
    expect_state("R4 program unlocked", 8'h80, 8'h08, 0, 0, 1);

    // R5 master lock
    wr(8'h60, 3'd0); wr(8'hF1, 3'd0);
    expect_state("R5 master without override", 8'h92, 8'h08, 0, 0, 1);
    wr(8'h50, 3'd0);
    rp_ovr = 1;
    wr(8'h60, 3'd0); wr(8'hF1, 3'd0); wait_ready(n);
    rp_ovr = 0;
    expect_state("R5 master with override", 8'h80, 8'h08, 1, 0, 1);

    // R6 set block lock under master
    wr(8'h60, 3'd6); wr(8'h01, 3'd6);
    expect_state("R6 block lock refused", 8'h92, 8'h08, 1, 0, 1);
    wr(8'h50, 3'd0);
    rp_ovr = 1;
    wr(8'h60, 3'd6); wr(8'h01, 3'd6); wait_ready(n);
    rp_ovr = 0;
    expect_state("R6 block lock with override", 8'h80, 8'h48, 1, 0, 1);

    // R8 program voltage low on clear
    vpp_ok = 0;
    wr(8'h60, 3'd0); wr(8'hD0, 3'd0);
    expect_state("R8 clear with vpp low", 8'hA8, 8'h48, 1, 0, 1);
    wr(8'h50, 3'd0);
    vpp_ok = 1;

    // R7 clear refused under master lock
    wr(8'h60, 3'd0); wr(8'hD0, 3'd0);
    expect_state("R7 clear refused", 8'hA2, 8'h48, 1, 0, 1);
    wr(8'h50, 3'd0);

    // R9 invalid second cycles
    wr(8'h60, 3'd0); wr(8'h33, 3'd0);
    expect_state("R9 invalid lock confirm", 8'hB0, 8'h48, 1, 0, 1);
    wr(8'h50, 3'd0);
    wr(8'h20, 3'd1); wr(8'hFF, 3'd1);
    expect_state("R9 invalid erase confirm", 8'hB0, 8'h48, 1, 0, 1);
    wr(8'h50, 3'd0);

    // R11 abort on the completion edge wins
    rp_ovr = 1;
    wr(8'h60, 3'd0); wr(8'hD0, 3'd0);
    repeat (BUSY - 1) begin @(posedge clk); #1; end
    vcc_ok = 0;
    @(posedge clk); #1;
    vcc_ok = 1;
    expect_state("R11 abort beats completion", 8'h80, 8'h48, 1, 1, 1);

    // R11 repeat clear resets flag; R7 all cleared at once; R12 master kept
    wr(8'h60, 3'd0); wr(8'hD0, 3'd0); wait_ready(n);
    rp_ovr = 0;
    expect_state("R7 R11 R12 clear all with override", 8'h80, 8'h00, 1, 0, 1);

    // R13 back to array read
    wr(8'hFF, 3'd0);
    expect_state("R13 read array mode", 8'h80, 8'h00, 1, 0, 0);
    wr(8'h70, 3'd0);
    expect_state("R13 read status mode", 8'h80, 8'h00, 1, 0, 1);

    repeat (2) @(posedge clk);
    report();
  end
endmodule